// File: doc/BRIEF.md
# Self-Repairing SECDED Word Memory

This block is a two-port word memory, with one port for writes and one for reads, in which every stored word carries its own single-error-correcting, double-error-detecting code. The write port encodes the data into a 72-bit stored codeword. The read port decodes the stored codeword one cycle after the request. It returns corrected data and raises one of two flags: a correctable single fault, or an uncorrectable double fault.

Correcting a word on the read path does not repair the copy held in the array. Contents that are loaded once and then only read, such as coefficient tables and ROM-like images, would therefore gather latent faults until one word holds two of them. To prevent this, the block can write the repaired codeword back to the same address in the cycle after the read result is presented. A user write always wins the write port in that cycle. A test input can flip one or two chosen bits of the stored codeword while a user write is in progress, so that both error paths can be reached.

Top module: `ecc_wb_mem`

## Requirements
- R1: A word written without injection reads back unchanged, with `rd_single` and `rd_double` both low.
- R2: `rd_valid`, `rd_data` and the flags are presented in the cycle after the one in which `rd_en` was high. `rd_valid` is low in every other cycle and after reset.
- R3: The stored codeword is 72 bits wide. Index 0 holds the overall parity. Indices 1, 2, 4, 8, 16, 32 and 64 hold check bits. The remaining indices carry data bits 0 to 63 in ascending order. When any one of these 72 bits is flipped, the read returns the original data with `rd_single` = 1 and `rd_double` = 0.
- R4: When two distinct stored bits are flipped, the read sets `rd_double` = 1 and `rd_single` = 0. It returns the stored data bits uncorrected, so a flipped data position shows up flipped.
- R5: If `wb_en` is high in a cycle where `rd_valid` and `rd_single` are high, the repaired codeword is written to the address that was read, at the next clock edge. A later read of that address is then clean.
- R6: If `wb_en` is low in that cycle, no writeback happens, and a later read still reports a single fault.
- R7: If a user write is requested in the cycle where a writeback would happen, the user write is performed and the writeback is dropped.
- R8: A double fault never causes a writeback. A later read reports the same double fault and the same data.
- R9: When a read and a user write hit the same address in the same cycle, the read returns the previous contents. Any writeback from that read is suppressed, so the newly written word survives.
- R10: `inj_mode` selects the injection: 00 flips nothing, 01 flips stored bit `inj_bit_a`, and 10 or 11 flips bits `inj_bit_a` and `inj_bit_b`. An index of 72 or more flips nothing. Injection acts only on user writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | User write request |
| wr_addr | input | 4 | User write address |
| wr_data | input | 64 | User write data |
| inj_mode | input | 2 | Fault injection selector |
| inj_bit_a | input | 7 | First stored bit index to flip |
| inj_bit_b | input | 7 | Second stored bit index to flip |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read address |
| wb_en | input | 1 | Permit writeback of the word being presented |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 64 | Corrected (or passed-through) read data |
| rd_single | output | 1 | Corrected single fault |
| rd_double | output | 1 | Uncorrectable double fault |

## Verification
The hardest states to reach from the ports are faults in the stored copy, because an ordinary write always stores a valid codeword. The injection inputs reach these states directly. The bench sweeps every one of the 72 single-bit positions and every unordered pair of distinct positions, and predicts the passed-through data from the bit layout. Writeback effects can only be seen by reading the same address again. The collision cases depend on exact cycle timing: a user write must land exactly in the presentation cycle, or in the same cycle as the read, and the bench drives these cycles explicitly.

// File: rtl/ecc_mem_pkg.sv
package ecc_mem_pkg;

   // Number of Hamming check bits needed to cover dw data bits.
   function automatic int ham_bits(input int dw);
      int p;
      p = 0;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   typedef enum logic [1:0] {
      INJ_NONE = 2'b00,
      INJ_ONE  = 2'b01,
      INJ_TWO  = 2'b10,
      INJ_TWOB = 2'b11
   } inj_mode_e;

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
   parameter int DATA_W = 64,
   parameter int P      = 7,
   parameter int CW_W   = DATA_W + P + 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CW_W-1:0]   cw
);

   always_comb begin
      int k;
      logic par;
      cw = '0;
      k  = 0;
      // Scatter data over the non-power-of-two positions.
      for (int j = 1; j < CW_W; j++) begin
         if ((j & (j - 1)) != 0) begin
            cw[j] = data[k];
            k++;
         end
      end
      // Each check bit covers the positions whose index has its bit set.
      for (int i = 0; i < P; i++) begin
         par = 1'b0;
         for (int j = 1; j < CW_W; j++) begin
            if (((j >> i) & 1) == 1) par = par ^ cw[j];
         end
         cw[1 << i] = par;
      end
      cw[0] = ^cw[CW_W-1:1];
   end

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec #(
   parameter int DATA_W = 64,
   parameter int P      = 7,
   parameter int CW_W   = DATA_W + P + 1
) (
   input  logic [CW_W-1:0]   cw,
   output logic [DATA_W-1:0] data,
   output logic              single,
   output logic              double,
   output logic [CW_W-1:0]   fixed
);

   logic [P-1:0] syn;
   logic         odd;
   logic         in_range;

   always_comb begin
      int k;
      syn = '0;
      for (int j = 1; j < CW_W; j++) begin
         if (cw[j]) syn = syn ^ P'(j);
      end
      odd      = ^cw;
      in_range = int'(syn) < CW_W;
      single   = odd && in_range;
      double   = (!odd && (syn != '0)) || (odd && !in_range);
      fixed    = cw;
      if (single) fixed[syn] = ~cw[syn];
      // Data is taken from the repaired word; on a double fault it is unchanged.
      data = '0;
      k    = 0;
      for (int j = 1; j < CW_W; j++) begin
         if ((j & (j - 1)) != 0) begin
            data[k] = fixed[j];
            k++;
         end
      end
   end

endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
   parameter int ADDR_W = 4,
   parameter int CW_W   = 72,
   parameter int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [CW_W-1:0]   wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [CW_W-1:0]   rdata
);

   logic [CW_W-1:0] mem [DEPTH];

   // Read-first: a read and a write to one address in one cycle see the old word.
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/ecc_wb_mem.sv
module ecc_wb_mem
   import ecc_mem_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int ADDR_W  = 4,
   parameter bit WB_IMPL = 1'b1,
   localparam int P      = ham_bits(DATA_W),
   localparam int CW_W   = DATA_W + P + 1,
   localparam int IDX_W  = $clog2(CW_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        inj_mode,
   input  logic [IDX_W-1:0]  inj_bit_a,
   input  logic [IDX_W-1:0]  inj_bit_b,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              wb_en,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_single,
   output logic              rd_double
);

   if (DATA_W < 8) begin : g_bad_dw
      $error("ecc_wb_mem: DATA_W must be at least 8");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
      $error("ecc_wb_mem: ADDR_W out of range");
   end

   logic [CW_W-1:0]   enc_cw;
   logic [CW_W-1:0]   inj_mask;
   logic [CW_W-1:0]   rd_cw;
   logic [CW_W-1:0]   dec_fixed;
   logic [DATA_W-1:0] dec_data;
   logic              dec_single;
   logic              dec_double;
   logic              rd_v_q;
   logic              clash_q;
   logic [ADDR_W-1:0] rd_addr_q;
   logic              wb_fire;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [CW_W-1:0]   mem_wdata;

   ecc_enc #(.DATA_W(DATA_W), .P(P), .CW_W(CW_W)) u_enc (
      .data (wr_data),
      .cw   (enc_cw)
   );

   always_comb begin
      inj_mask = '0;
      if (inj_mode != INJ_NONE && int'(inj_bit_a) < CW_W) inj_mask[inj_bit_a] = 1'b1;
      if (inj_mode[1] && int'(inj_bit_b) < CW_W)            inj_mask[inj_bit_b] = 1'b1;
   end

   ecc_store #(.ADDR_W(ADDR_W), .CW_W(CW_W)) u_store (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_addr),
      .wdata (mem_wdata),
      .re    (rd_en),
      .raddr (rd_addr),
      .rdata (rd_cw)
   );

   ecc_dec #(.DATA_W(DATA_W), .P(P), .CW_W(CW_W)) u_dec (
      .cw     (rd_cw),
      .data   (dec_data),
      .single (dec_single),
      .double (dec_double),
      .fixed  (dec_fixed)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_v_q    <= 1'b0;
         clash_q   <= 1'b0;
         rd_addr_q <= '0;
      end else begin
         rd_v_q <= rd_en;
         if (rd_en) begin
            rd_addr_q <= rd_addr;
            clash_q   <= wr_en && (wr_addr == rd_addr);
         end
      end
   end

   if (WB_IMPL) begin : g_wb
      assign wb_fire = rd_v_q && dec_single && wb_en && !clash_q && !wr_en;
   end else begin : g_no_wb
      assign wb_fire = 1'b0;
   end

   assign mem_we    = wr_en | wb_fire;
   assign mem_addr  = wr_en ? wr_addr : rd_addr_q;
   assign mem_wdata = wr_en ? (enc_cw ^ inj_mask) : dec_fixed;

   assign rd_valid  = rd_v_q;
   assign rd_data   = dec_data;
   assign rd_single = rd_v_q & dec_single;
   assign rd_double = rd_v_q & dec_double;

endmodule

// File: rtl/ecc_wb_mem_chk.sv
module ecc_wb_mem_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wb_en,
   input logic              rd_valid,
   input logic              rd_double,
   input logic              wb_fire,
   input logic              mem_we
);

   // R2
   rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid);
   // R2
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid);
   // R5
   wb_port_chk: assert property (@(posedge clk) disable iff (!rst_n) wb_fire |-> mem_we && rd_valid);
   // R6
   wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) !wb_en |-> !wb_fire);
   // R7
   wb_yield_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !wb_fire);
   // R8
   no_dbl_wb_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_double |-> !wb_fire);
   // R9
   clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en && rd_addr == wr_addr) |=> !wb_fire);

endmodule

bind ecc_wb_mem ecc_wb_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_en     (rd_en),
   .rd_addr   (rd_addr),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wb_en     (wb_en),
   .rd_valid  (rd_valid),
   .rd_double (rd_double),
   .wb_fire   (wb_fire),
   .mem_we    (mem_we)
);

// File: tb/ecc_wb_mem_tb_top.sv
`timescale 1ns/1ps
module ecc_wb_mem_tb_top;

   localparam int DW = 64;
   localparam int AW = 4;
   localparam int CW = 72;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0]    inj_mode = 2'b00;
   logic [6:0]    inj_bit_a = '0;
   logic [6:0]    inj_bit_b = '0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          wb_en = 1'b0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          rd_single;
   logic          rd_double;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ecc_wb_mem #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .inj_mode(inj_mode), .inj_bit_a(inj_bit_a), .inj_bit_b(inj_bit_b),
      .rd_en(rd_en), .rd_addr(rd_addr), .wb_en(wb_en), .rd_valid(rd_valid),
      .rd_data(rd_data), .rd_single(rd_single), .rd_double(rd_double)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Flip the data bits that sit at stored indices a and b (layout of R3).
   function automatic logic [DW-1:0] flip_data(input logic [DW-1:0] d, input int a, input int b);
      logic [DW-1:0] r;
      int k;
      r = d;
      k = 0;
      for (int j = 1; j < CW; j++) begin
         if ((j & (j - 1)) != 0) begin
            if (j == a || j == b) r[k] = ~r[k];
            k++;
         end
      end
      return r;
   endfunction

   function automatic logic [DW-1:0] pat(input int n);
      return 64'h9E37_79B9_7F4A_7C15 * DW'(n + 1) ^ DW'(n) << 17;
   endfunction

   task automatic do_write(input int addr, input logic [DW-1:0] d, input int mode, input int a, input int b);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = d;
      inj_mode = 2'(mode); inj_bit_a = 7'(a); inj_bit_b = 7'(b);
      @(negedge clk);
      wr_en = 1'b0; inj_mode = 2'b00;
   endtask

   task automatic do_read(input int addr, input bit wbe, output logic [DW-1:0] d,
                          output logic s, output logic db, output logic v);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = AW'(addr); wb_en = wbe;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_valid; d = rd_data; s = rd_single; db = rd_double;
      @(negedge clk);
      wb_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      logic s, db, v;
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2 reset valid", DW'(rd_valid), 0);
      chk("R2 reset single", DW'(rd_single), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: clean words at every address
      for (int i = 0; i < 16; i++) do_write(i, pat(i), 0, 0, 0);
      for (int i = 0; i < 16; i++) begin
         do_read(i, 1'b1, d, s, db, v);
         chk("R1 data", d, pat(i));
         chk("R1 flags", DW'({s, db}), 0);
         chk("R2 valid", DW'(v), 1);
         chk("R2 valid drops", DW'(rd_valid), 0);
      end

      // R3, R5: every single-bit position, repaired by writeback
      for (int a = 0; a < CW; a++) begin
         do_write(a % 16, pat(a + 100), 1, a, 0);
         do_read(a % 16, 1'b1, d, s, db, v);
         chk("R3 data", d, pat(a + 100));
         chk("R3 flags", DW'({s, db}), 2);
         do_read(a % 16, 1'b0, d, s, db, v);
         chk("R5 repaired data", d, pat(a + 100));
         chk("R5 repaired flags", DW'({s, db}), 0);
      end

      // R4, R8: every pair of distinct positions
      for (int a = 0; a < CW; a++) begin
         for (int b = a + 1; b < CW; b++) begin
            do_write((a + b) % 16, pat(a * 80 + b), 2, a, b);
            do_read((a + b) % 16, 1'b1, d, s, db, v);
            chk("R4 data", d, flip_data(pat(a * 80 + b), a, b));
            chk("R4 flags", DW'({s, db}), 1);
            do_read((a + b) % 16, 1'b1, d, s, db, v);
            chk("R8 data kept", d, flip_data(pat(a * 80 + b), a, b));
            chk("R8 flags kept", DW'({s, db}), 1);
         end
      end

      // R6: writeback not permitted leaves the fault in place
      for (int a = 0; a < CW; a += 7) begin
         do_write(3, pat(a + 500), 1, a, 0);
         do_read(3, 1'b0, d, s, db, v);
         do_read(3, 1'b0, d, s, db, v);
         chk("R6 data", d, pat(a + 500));
         chk("R6 still single", DW'({s, db}), 2);
      end

      // R7: user write in the presentation cycle wins, writeback dropped
      do_write(5, pat(900), 1, 40, 0);
      do_write(6, pat(901), 0, 0, 0);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 4'd5; wb_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk("R7 presented single", DW'(rd_single), 1);
      wr_en = 1'b1; wr_addr = 4'd6; wr_data = pat(902);
      @(negedge clk);
      wr_en = 1'b0; wb_en = 1'b0;
      do_read(5, 1'b0, d, s, db, v);
      chk("R7 fault remains", DW'({s, db}), 2);
      chk("R7 data", d, pat(900));
      do_read(6, 1'b0, d, s, db, v);
      chk("R7 user word", d, pat(902));

      // R9: read and write to one address in one cycle
      do_write(4, pat(910), 1, 9, 0);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 4'd4; wb_en = 1'b1;
      wr_en = 1'b1; wr_addr = 4'd4; wr_data = pat(911);
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      chk("R9 old data", rd_data, pat(910));
      chk("R9 old single", DW'(rd_single), 1);
      @(negedge clk);
      wb_en = 1'b0;
      do_read(4, 1'b0, d, s, db, v);
      chk("R9 new word survives", d, pat(911));
      chk("R9 new flags", DW'({s, db}), 0);

      // R10: out-of-range indices and mode selection
      for (int a = CW; a < 128; a++) begin
         do_write(7, pat(a), 1, a, 3);
         do_read(7, 1'b0, d, s, db, v);
         chk("R10 ignored index", DW'({s, db}), 0);
         chk("R10 data", d, pat(a));
      end
      do_write(8, pat(1), 1, 5, 20);
      do_read(8, 1'b0, d, s, db, v);
      chk("R10 mode 01 single", DW'({s, db}), 2);
      do_write(8, pat(2), 3, 5, 20);
      do_read(8, 1'b0, d, s, db, v);
      chk("R10 mode 11 double", DW'({s, db}), 1);
      do_write(8, pat(3), 0, 5, 20);
      do_read(8, 1'b0, d, s, db, v);
      chk("R10 mode 00 clean", DW'({s, db}), 0);

      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule